// File: doc/BRIEF.md
# Strobe-Controlled CRC-16 Word Engine

This block keeps a running CRC-16 (polynomial 0x1021, no reflection, no final XOR) over the 32-bit words that cross a parallel bus interface. It sits beside the interface state machine. That machine raises single-cycle strobes: one loads a programmable start value, and one, together with a word transfer, folds the whole 32-bit word into the running value in a single clock. A transfer is either a transmit-side pop or a receive-side push. A configuration bit chooses whether the word's bytes enter the CRC high byte first or low byte first. This choice is independent of how the bus itself orders bytes.

The engine can also close a frame in both directions. On the transmit side, a use-CRC control together with the output-update control puts the running CRC onto the outgoing bus in place of payload. On the receive side, a use-CRC control together with a push takes the incoming word as the far end's CRC. It records that a CRC arrived and whether it equals the locally computed value. The running CRC is visible on an output at all times. Nothing happens while the global enable is low.

Top module: `crc16w_engine`

## Requirements
- R1: After a synchronous reset, crc_value is 0xFFFF and crc_received and crc_match are 0.
- R2: While cfg_enable is 0, crc_value, crc_received and crc_match keep their values whatever the strobes do, and tx_data_out equals tx_data_in.
- R3: With cfg_enable at 1, strb_init loads cfg_init_value into crc_value on the next clock and clears crc_received and crc_match. When init is raised together with calculate or a capture, init wins.
- R4: crc_value changes only when strb_calc is high in the same cycle as xfer_pop or xfer_push, with strb_use_crc low. A pop absorbs tx_data_in and a push absorbs rx_data_in. When both are high, tx_data_in is absorbed.
- R5: Each update absorbs all 32 bits of the word with polynomial 0x1021, MSB-first bit order, no reflection and no final XOR. Starting from 0xFFFF, the words 0xC0DE1000 to 0xC0DE1007 absorbed high byte first give 0x5C66 and not 0xFB97.
- R6: With cfg_lsb_first at 0, the bytes enter in the order bits [31:24], [23:16], [15:8], [7:0]. With cfg_lsb_first at 1, they enter in the order [7:0], [15:8], [23:16], [31:24].
- R7: While cfg_enable, strb_use_crc and strb_upd_dout are all 1, tx_data_out is {16'h0000, crc_value} in the same cycle. Otherwise tx_data_out equals tx_data_in.
- R8: With cfg_enable at 1, strb_use_crc and xfer_push together capture a received CRC. On the next clock crc_received is 1, and crc_match is 1 exactly when rx_data_in[15:0] equals the crc_value held before that clock. The captured word is not absorbed, even if strb_calc is high.
- R9: crc_match is never 1 while crc_received is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_enable | input | 1 | Global enable |
| cfg_init_value | input | 16 | Value loaded by the init strobe |
| cfg_lsb_first | input | 1 | Byte order select: 0 high byte first, 1 low byte first |
| strb_init | input | 1 | Load the start value |
| strb_calc | input | 1 | Absorb the word transferred in this cycle |
| strb_use_crc | input | 1 | Mark the current transfer as a CRC word |
| strb_upd_dout | input | 1 | Output bus update from the state machine |
| xfer_pop | input | 1 | Transmit-side word transfer |
| xfer_push | input | 1 | Receive-side word transfer |
| tx_data_in | input | 32 | Outgoing payload word |
| rx_data_in | input | 32 | Incoming bus word |
| tx_data_out | output | 32 | Outgoing bus word, payload or CRC |
| crc_value | output | 16 | Running CRC |
| crc_received | output | 1 | A far-end CRC word has been captured |
| crc_match | output | 1 | The captured CRC equals the local CRC |

## Verification
Two kinds of event can fall in the same cycle. The first is a start-value load together with a calculate-and-transfer. The bench raises init, calculate and pop in one cycle and expects the loaded value with no word absorbed. The second is a CRC capture together with a calculate on a push. The bench raises use-CRC, calculate and push together. It expects the flags to report the comparison against the pre-capture CRC, while the running value stays unchanged. A capture raised in the same cycle as init is also checked, and the cleared flags must win.

// File: rtl/crc16w_pkg.sv
package crc16w_pkg;

    parameter int CRC_W  = 16;
    parameter int WORD_W = 32;
    localparam int BYTE_W = 8;
    localparam int BYTES  = WORD_W / BYTE_W;
    parameter logic [CRC_W-1:0] POLY = 16'h1021;

    typedef logic [CRC_W-1:0]  crc_t;
    typedef logic [WORD_W-1:0] word_t;
    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic {
        ORDER_HIGH_FIRST = 1'b0,
        ORDER_LOW_FIRST  = 1'b1
    } byte_order_e;

    typedef struct packed {
        logic        enable;
        crc_t        init_value;
        byte_order_e order;
    } crc_cfg_t;

    typedef struct packed {
        logic init;
        logic calc;
        logic use_crc;
        logic upd_dout;
        logic pop;
        logic push;
    } crc_ctl_t;

    // One byte through the shift register, MSB first, no reflection.
    function automatic crc_t crc_byte_step(crc_t cur, byte_t din);
        crc_t r;
        r = cur ^ {din, {(CRC_W-BYTE_W){1'b0}}};
        for (int i = 0; i < BYTE_W; i++) begin
            r = r[CRC_W-1] ? ((r << 1) ^ POLY) : (r << 1);
        end
        return r;
    endfunction

    // Byte number idx (0 = first to enter) of a word under the chosen order.
    function automatic byte_t byte_pick(word_t w, int idx, byte_order_e ord);
        if (ord == ORDER_HIGH_FIRST)
            return w[WORD_W-1-BYTE_W*idx -: BYTE_W];
        else
            return w[BYTE_W*idx +: BYTE_W];
    endfunction

endpackage

// File: rtl/crc16w_word_step.sv
module crc16w_word_step
    import crc16w_pkg::*;
(
    input  crc_t        crc_in,
    input  word_t       word_in,
    input  byte_order_e order,
    output crc_t        crc_out
);
    crc_t chain [0:BYTES];

    assign chain[0] = crc_in;

    for (genvar g = 0; g < BYTES; g++) begin : g_byte
        assign chain[g+1] = crc_byte_step(chain[g], byte_pick(word_in, g, order));
    end

    assign crc_out = chain[BYTES];
endmodule

// File: rtl/crc16w_core.sv
module crc16w_core
    import crc16w_pkg::*;
#(
    parameter crc_t RESET_VALUE = 16'hFFFF
) (
    input  logic     clk,
    input  logic     rst,
    input  crc_cfg_t cfg,
    input  crc_ctl_t ctl,
    input  word_t    tx_word,
    input  word_t    rx_word,
    output crc_t     crc_q,
    output logic     received_q,
    output logic     match_q
);
    logic  do_init;
    logic  do_capture;
    logic  do_absorb;
    word_t absorb_word;
    crc_t  crc_next;

    always_comb begin
        do_init     = cfg.enable & ctl.init;
        do_capture  = cfg.enable & ctl.use_crc & ctl.push;
        do_absorb   = cfg.enable & ctl.calc & (ctl.pop | ctl.push) & ~ctl.use_crc;
        absorb_word = ctl.pop ? tx_word : rx_word;
    end

    crc16w_word_step i_step (
        .crc_in  (crc_q),
        .word_in (absorb_word),
        .order   (cfg.order),
        .crc_out (crc_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            crc_q      <= RESET_VALUE;
            received_q <= 1'b0;
            match_q    <= 1'b0;
        end else if (do_init) begin
            crc_q      <= cfg.init_value;
            received_q <= 1'b0;
            match_q    <= 1'b0;
        end else begin
            if (do_absorb) begin
                crc_q <= crc_next;
            end
            if (do_capture) begin
                received_q <= 1'b1;
                match_q    <= (rx_word[CRC_W-1:0] == crc_q);
            end
        end
    end
endmodule

// File: rtl/crc16w_tx_mux.sv
module crc16w_tx_mux
    import crc16w_pkg::*;
(
    input  logic  substitute,
    input  crc_t  crc,
    input  word_t payload,
    output word_t bus_out
);
    localparam int PAD_W = WORD_W - CRC_W;

    always_comb begin
        if (substitute)
            bus_out = {{PAD_W{1'b0}}, crc};
        else
            bus_out = payload;
    end
endmodule

// File: rtl/crc16w_engine.sv
module crc16w_engine
    import crc16w_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_enable,
    input  logic [15:0] cfg_init_value,
    input  logic        cfg_lsb_first,
    input  logic        strb_init,
    input  logic        strb_calc,
    input  logic        strb_use_crc,
    input  logic        strb_upd_dout,
    input  logic        xfer_pop,
    input  logic        xfer_push,
    input  logic [31:0] tx_data_in,
    input  logic [31:0] rx_data_in,
    output logic [31:0] tx_data_out,
    output logic [15:0] crc_value,
    output logic        crc_received,
    output logic        crc_match
);
    crc_cfg_t cfg;
    crc_ctl_t ctl;
    logic     substitute;

    always_comb begin
        cfg.enable     = cfg_enable;
        cfg.init_value = cfg_init_value;
        cfg.order      = cfg_lsb_first ? ORDER_LOW_FIRST : ORDER_HIGH_FIRST;
        ctl.init       = strb_init;
        ctl.calc       = strb_calc;
        ctl.use_crc    = strb_use_crc;
        ctl.upd_dout   = strb_upd_dout;
        ctl.pop        = xfer_pop;
        ctl.push       = xfer_push;
        substitute     = cfg_enable & strb_use_crc & strb_upd_dout;
    end

    crc16w_core #(.RESET_VALUE(16'hFFFF)) i_core (
        .clk        (clk),
        .rst        (rst),
        .cfg        (cfg),
        .ctl        (ctl),
        .tx_word    (tx_data_in),
        .rx_word    (rx_data_in),
        .crc_q      (crc_value),
        .received_q (crc_received),
        .match_q    (crc_match)
    );

    crc16w_tx_mux i_mux (
        .substitute (substitute),
        .crc        (crc_value),
        .payload    (tx_data_in),
        .bus_out    (tx_data_out)
    );
endmodule

// File: rtl/crc16w_checker.sv
module crc16w_checker (
    input logic        clk,
    input logic        rst,
    input logic        cfg_enable,
    input logic [15:0] cfg_init_value,
    input logic        strb_init,
    input logic        strb_calc,
    input logic        strb_use_crc,
    input logic        strb_upd_dout,
    input logic        xfer_pop,
    input logic        xfer_push,
    input logic [31:0] tx_data_in,
    input logic [31:0] tx_data_out,
    input logic [15:0] crc_value,
    input logic        crc_received,
    input logic        crc_match
);
    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (crc_value == 16'hFFFF && !crc_received && !crc_match));

    assert_disabled_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !cfg_enable |=> ($stable(crc_value) && $stable(crc_received) && $stable(crc_match)));

    assert_init_load_R3: assert property (@(posedge clk) disable iff (rst)
        (cfg_enable && strb_init) |=>
            (crc_value == $past(cfg_init_value) && !crc_received && !crc_match));

    assert_no_spurious_update_R4: assert property (@(posedge clk) disable iff (rst)
        (cfg_enable && !strb_init && !(strb_calc && !strb_use_crc && (xfer_pop || xfer_push)))
            |=> $stable(crc_value));

    assert_crc_on_bus_R7: assert property (@(posedge clk) disable iff (rst)
        (cfg_enable && strb_use_crc && strb_upd_dout) |-> (tx_data_out == {16'h0000, crc_value}));

    assert_payload_pass_R7: assert property (@(posedge clk) disable iff (rst)
        !(cfg_enable && strb_use_crc && strb_upd_dout) |-> (tx_data_out == tx_data_in));

    assert_capture_flag_R8: assert property (@(posedge clk) disable iff (rst)
        (cfg_enable && strb_use_crc && xfer_push && !strb_init) |=> crc_received);

    assert_match_implies_received_R9: assert property (@(posedge clk) disable iff (rst)
        crc_match |-> crc_received);
endmodule

bind crc16w_engine crc16w_checker i_crc16w_checker (
    .clk            (clk),
    .rst            (rst),
    .cfg_enable     (cfg_enable),
    .cfg_init_value (cfg_init_value),
    .strb_init      (strb_init),
    .strb_calc      (strb_calc),
    .strb_use_crc   (strb_use_crc),
    .strb_upd_dout  (strb_upd_dout),
    .xfer_pop       (xfer_pop),
    .xfer_push      (xfer_push),
    .tx_data_in     (tx_data_in),
    .tx_data_out    (tx_data_out),
    .crc_value      (crc_value),
    .crc_received   (crc_received),
    .crc_match      (crc_match)
);

// File: tb/test_crc16w_engine.sv
`timescale 1ns/1ps
module test_crc16w_engine;
    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_enable;
    logic [15:0] cfg_init_value;
    logic        cfg_lsb_first;
    logic        strb_init, strb_calc, strb_use_crc, strb_upd_dout;
    logic        xfer_pop, xfer_push;
    logic [31:0] tx_data_in, rx_data_in;
    logic [31:0] tx_data_out;
    logic [15:0] crc_value;
    logic        crc_received, crc_match;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    crc16w_engine i_crc16w_engine (
        .clk(clk), .rst(rst), .cfg_enable(cfg_enable), .cfg_init_value(cfg_init_value),
        .cfg_lsb_first(cfg_lsb_first), .strb_init(strb_init), .strb_calc(strb_calc),
        .strb_use_crc(strb_use_crc), .strb_upd_dout(strb_upd_dout), .xfer_pop(xfer_pop),
        .xfer_push(xfer_push), .tx_data_in(tx_data_in), .rx_data_in(rx_data_in),
        .tx_data_out(tx_data_out), .crc_value(crc_value), .crc_received(crc_received),
        .crc_match(crc_match)
    );

    // Bit-serial reference: 32 bits, first byte of the chosen order first.
    function automatic logic [15:0] ref_word(logic [15:0] c, logic [31:0] w, bit low_first);
        logic [31:0] s;
        logic fb;
        s = low_first ? {w[7:0], w[15:8], w[23:16], w[31:24]} : w;
        for (int k = 31; k >= 0; k--) begin
            fb = c[15] ^ s[k];
            c  = {c[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
        end
        return c;
    endfunction

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic quiet();
        strb_init = 0; strb_calc = 0; strb_use_crc = 0; strb_upd_dout = 0;
        xfer_pop = 0; xfer_push = 0;
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic do_init(logic [15:0] v);
        quiet(); cfg_init_value = v; strb_init = 1; tick(); quiet();
    endtask

    task automatic feed_vector(bit on_push);
        for (int i = 0; i < 8; i++) begin
            strb_calc = 1;
            if (on_push) begin xfer_push = 1; rx_data_in = 32'hC0DE1000 + i; end
            else         begin xfer_pop  = 1; tx_data_in = 32'hC0DE1000 + i; end
            tick();
        end
        quiet();
    endtask

    task automatic t_reset();
        rst = 1; quiet(); cfg_enable = 1; cfg_lsb_first = 0; cfg_init_value = 16'h0000;
        tx_data_in = 32'h0; rx_data_in = 32'h0;
        tick(); tick(); rst = 0;
        check("R1", "crc after reset", {16'h0, crc_value}, 32'h0000FFFF);
        check("R1", "flags after reset", {30'h0, crc_received, crc_match}, 32'h0);
    endtask

    task automatic t_vector_pop();
        do_init(16'hFFFF);
        check("R3", "init load", {16'h0, crc_value}, 32'h0000FFFF);
        feed_vector(0);
        check("R5", "vector high first on pop", {16'h0, crc_value}, 32'h00005C66);
        check("R5", "not low-16 result", {31'h0, crc_value == 16'hFB97}, 32'h0);
    endtask

    task automatic t_vector_push();
        do_init(16'hFFFF);
        feed_vector(1);
        check("R4", "vector on push path", {16'h0, crc_value}, 32'h00005C66);
    endtask

    task automatic t_low_first();
        logic [15:0] e;
        cfg_lsb_first = 1;
        do_init(16'hFFFF);
        e = 16'hFFFF;
        for (int i = 0; i < 8; i++) begin
            e = ref_word(e, 32'hC0DE1000 + i, 1);
            strb_calc = 1; xfer_pop = 1; tx_data_in = 32'hC0DE1000 + i; tick();
        end
        quiet();
        check("R6", "low byte first order", {16'h0, crc_value}, {16'h0, e});
        cfg_lsb_first = 0;
        do_init(16'h1D0F);
        strb_calc = 1; xfer_pop = 1; tx_data_in = 32'h12345678; tick(); quiet();
        check("R6", "high byte first single word", {16'h0, crc_value},
              {16'h0, ref_word(16'h1D0F, 32'h12345678, 0)});
    endtask

    task automatic t_no_update();
        do_init(16'h4321);
        strb_calc = 1; tx_data_in = 32'hDEADBEEF; tick(); quiet();
        check("R4", "calc without transfer", {16'h0, crc_value}, 32'h00004321);
        xfer_pop = 1; xfer_push = 1; tick(); quiet();
        check("R4", "transfer without calc", {16'h0, crc_value}, 32'h00004321);
        strb_calc = 1; xfer_pop = 1; xfer_push = 1;
        tx_data_in = 32'hA5A5_0001; rx_data_in = 32'h5A5A_0002; tick(); quiet();
        check("R4", "pop and push together uses tx word", {16'h0, crc_value},
              {16'h0, ref_word(16'h4321, 32'hA5A5_0001, 0)});
    endtask

    task automatic t_init_priority();
        do_init(16'hFFFF);
        cfg_init_value = 16'hABCD; strb_init = 1; strb_calc = 1; xfer_pop = 1;
        tx_data_in = 32'h11112222; tick(); quiet();
        check("R3", "init beats calc", {16'h0, crc_value}, 32'h0000ABCD);
    endtask

    task automatic t_disabled();
        do_init(16'h7777);
        cfg_enable = 0;
        cfg_init_value = 16'h0101; strb_init = 1; tick(); quiet();
        strb_calc = 1; xfer_pop = 1; tx_data_in = 32'h01020304; tick(); quiet();
        strb_use_crc = 1; xfer_push = 1; rx_data_in = 32'h7777; tick(); quiet();
        check("R2", "crc held while disabled", {16'h0, crc_value}, 32'h00007777);
        check("R2", "no capture while disabled", {31'h0, crc_received}, 32'h0);
        strb_use_crc = 1; strb_upd_dout = 1; tx_data_in = 32'hCAFEF00D; #1;
        check("R2", "no substitution while disabled", tx_data_out, 32'hCAFEF00D);
        quiet(); cfg_enable = 1;
    endtask

    task automatic t_substitute();
        do_init(16'hFFFF);
        feed_vector(0);
        tx_data_in = 32'h89ABCDEF; strb_use_crc = 1; strb_upd_dout = 1; #1;
        check("R7", "crc driven on bus", tx_data_out, 32'h00005C66);
        strb_use_crc = 0; #1;
        check("R7", "payload without use_crc", tx_data_out, 32'h89ABCDEF);
        strb_use_crc = 1; strb_upd_dout = 0; #1;
        check("R7", "payload without update", tx_data_out, 32'h89ABCDEF);
        quiet();
    endtask

    task automatic t_capture();
        do_init(16'hFFFF);
        feed_vector(1);
        strb_use_crc = 1; xfer_push = 1; strb_calc = 1; rx_data_in = 32'h00005C67; tick(); quiet();
        check("R8", "received after bad crc", {31'h0, crc_received}, 32'h1);
        check("R8", "mismatch flagged", {31'h0, crc_match}, 32'h0);
        check("R8", "crc word not absorbed", {16'h0, crc_value}, 32'h00005C66);
        strb_use_crc = 1; xfer_push = 1; strb_calc = 1; rx_data_in = 32'hFFFF5C66; tick(); quiet();
        check("R8", "match on equal low half", {31'h0, crc_match}, 32'h1);
        check("R9", "match with received", {31'h0, crc_received}, 32'h1);
        cfg_init_value = 16'hFFFF; strb_init = 1; strb_use_crc = 1; xfer_push = 1;
        rx_data_in = 32'h0000FFFF; tick(); quiet();
        check("R3", "init clears flags over capture", {30'h0, crc_received, crc_match}, 32'h0);
        check("R9", "no match without received", {31'h0, crc_match}, 32'h0);
    endtask

    initial begin
        t_reset();
        t_vector_pop();
        t_vector_push();
        t_low_first();
        t_no_update();
        t_init_priority();
        t_disabled();
        t_substitute();
        t_capture();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule